// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block gathers device interrupt lines, a counter/timer line for each processor and a set of software interrupts for each processor. It reduces them to one 4-bit interrupt level for each CPU. Each source has its own mask bit. Many sources share one level, so the level says how urgent the interrupt is but not which source raised it. Software finds the source by reading the pending registers.

The global block holds the device mask and a target register. Software changes the device mask only through a write-one-to-set register and a write-one-to-clear register. The target register picks which CPU receives device interrupts. The one exception is the asynchronous-error source, which goes to every CPU. Each CPU block has a read-only pending view, software-interrupt set and clear registers, and a local mask for its own timer. Any processor can write any CPU's set register, so one processor raises an inter-processor interrupt on another by writing a software bit into that CPU's set register. The register port is a single write strobe with a combinational read. Reads never change state.

The output levels are registered. A write or an input change is reflected in the levels at the next rising clock edge. The level is computed from the register values that edge produces, so a mask write and a line change in the same cycle combine without a glitch.

Top module: `mpil_ctrl`

## Requirements
- R1: After reset every device mask bit and the master bit (global mask bit 31) are 1, every local timer mask is 1, every software bit is 0 and every level output is 0. The global mask reads back as 0xFFFFFFFF, and each CPU's local mask reads back as 0x00000080.
- R2: A write to the mask-set register sets the global mask bits where the data is 1. A write to the mask-clear register clears them where the data is 1. Bits written as 0 keep their value. A mask bit of 1 blocks its source.
- R3: While global mask bit 31 is 1, every level output is 0, whatever is pending. Clearing bit 31 lets pending sources through again.
- R4: An unmasked, asserted device line at bit i gives this level: 15→15 (asynchronous error), 16→4, 17→6, 18→8, 19→10 (system counter/timer), 20→13, 21→12, 22→12, 23→11, 24→2, 25→3, 26→5, 27→7, 28→9, 29→11, 30→13. All other device bits raise no level.
- R5: Device sources at levels below 15 reach only the CPU named by the target register, which resets to 0. Device bit 15 reaches every CPU.
- R6: Writing a 1 to bit 16+n (n = 1..15) of a CPU's software-set register sets that CPU's software interrupt at level n. Any processor may make this write, which raises an inter-processor interrupt. The software-clear register clears the same bits. Bit 16 and the lower bits of these writes are ignored.
- R7: A CPU's own timer line raises level 14 on that CPU only, unless local mask bit 7 of that CPU is 1. Local-mask-set and local-mask-clear registers change that bit with write-one semantics on data bit 7.
- R8: Each CPU's level is the highest level among its unmasked pending sources, or 0 when none is pending.
- R9: A CPU's pending register reads software level n at bit 16+n and that CPU's raw timer line at bit 7, with all other bits 0. The global pending register reads the raw device lines at bits 0..30, with bit 31 = 0. Reads have no side effects.
- R10: A register write or an input change shows in the level outputs one rising edge later. A mask-set write in the same cycle as its line rises keeps the level from ever showing that source.
- R11: The word address is block*8 + offset. CPU block c (c < NCPU) has these offsets: 0 pending, 1 software set, 2 software clear, 3 local mask, 4 local mask set, 5 local mask clear. The global block (block NCPU) has these offsets: 0 pending, 1 mask, 2 mask set, 3 mask clear, 4 target. Unused or write-only offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 31 | Device interrupt lines, active high |
| cpu_tmr | input | NCPU | Timer line of each processor |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pil | output | 4*NCPU | Interrupt level, 4 bits per CPU, CPU c at bits 4c+3..4c |

## Verification
Two things can land on the same clock edge: a write to the global mask registers and a change of the device line that mask bit guards. The bench drives a mask-set write in the same cycle that line 17 rises. It then checks that the target CPU's level stays 0 in that cycle and in the cycle after. It then drives a mask-clear write while the line is held, and checks that level 6 appears exactly one edge later. A second overlap comes from software priority. A timer tick, a local mask write and pending software levels all feed one encoder, and the bench checks the winning level after each single change.

// File: rtl/mpil_pkg.sv
package mpil_pkg;

    localparam int WORD      = 32;
    localparam int LVLS      = 16;
    localparam int BLK_WORDS = 8;
    localparam int NDEV      = WORD - 1;
    localparam int SOFT_LSB  = 16;
    localparam int TMR_BIT   = 7;
    localparam int TMR_LVL   = 14;
    localparam int ERR_LVL   = 15;

    typedef enum logic [2:0] {
        CO_PEND  = 3'd0,
        CO_SSET  = 3'd1,
        CO_SCLR  = 3'd2,
        CO_LMASK = 3'd3,
        CO_LMSET = 3'd4,
        CO_LMCLR = 3'd5
    } cpu_off_e;

    typedef enum logic [2:0] {
        GO_PEND = 3'd0,
        GO_MASK = 3'd1,
        GO_MSET = 3'd2,
        GO_MCLR = 3'd3,
        GO_TGT  = 3'd4
    } glb_off_e;

    // Level that a device line at bit position i raises; 0 means none.
    function automatic logic [3:0] src_level(input int i);
        logic [3:0] l;
        case (i)
            15:      l = 4'd15;
            16:      l = 4'd4;
            17:      l = 4'd6;
            18:      l = 4'd8;
            19:      l = 4'd10;
            20:      l = 4'd13;
            21, 22:  l = 4'd12;
            23:      l = 4'd11;
            24:      l = 4'd2;
            25:      l = 4'd3;
            26:      l = 4'd5;
            27:      l = 4'd7;
            28:      l = 4'd9;
            29:      l = 4'd11;
            30:      l = 4'd13;
            default: l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/mpil_prio.sv
module mpil_prio
    import mpil_pkg::*;
(
    input  logic [LVLS-1:0] vec,
    output logic [3:0]      lvl
);

    always_comb begin
        lvl = 4'd0;
        for (int i = 1; i < LVLS; i++) begin
            if (vec[i]) lvl = 4'(i);
        end
    end

endmodule

// File: rtl/mpil_glb.sv
module mpil_glb
    import mpil_pkg::*;
#(
    parameter int CW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mset,
    input  logic            wr_mclr,
    input  logic            wr_tgt,
    input  logic [WORD-1:0] wdata,
    input  logic [NDEV-1:0] dev_irq,
    output logic [WORD-1:0] gmask_q,
    output logic [CW-1:0]   tgt_q,
    output logic [CW-1:0]   tgt_nx,
    output logic            halt_nx,
    output logic [LVLS-1:0] lvl_any
);

    logic [WORD-1:0] gmask_nx;

    always_comb begin
        gmask_nx = gmask_q;
        if (wr_mset) gmask_nx = gmask_q | wdata;
        else if (wr_mclr) gmask_nx = gmask_q & ~wdata;
        tgt_nx = wr_tgt ? wdata[CW-1:0] : tgt_q;
    end

    assign halt_nx = gmask_nx[WORD-1];

    always_comb begin
        lvl_any = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_irq[i] && !gmask_nx[i] && (src_level(i) != 4'd0))
                lvl_any[src_level(i)] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gmask_q <= '1;
            tgt_q   <= '0;
        end else begin
            gmask_q <= gmask_nx;
            tgt_q   <= tgt_nx;
        end
    end

    // R2
    gmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((gmask_q & $past(wdata)) == $past(wdata)));

    // R2
    gmask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((gmask_q & $past(wdata)) == '0));

endmodule

// File: rtl/mpil_cpu.sv
module mpil_cpu
    import mpil_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic            wr_lmset,
    input  logic            wr_lmclr,
    input  logic [LVLS-1:0] sw,
    input  logic            lbit,
    input  logic            tmr,
    input  logic [LVLS-1:0] glb_lvl,
    input  logic            halt,
    output logic [LVLS-1:0] soft_q,
    output logic            lmask_q,
    output logic [3:0]      pil_q
);

    logic [LVLS-1:0] soft_nx;
    logic [LVLS-1:0] vec;
    logic            lmask_nx;
    logic [3:0]      enc_lvl;

    always_comb begin
        soft_nx = soft_q;
        if (wr_set) soft_nx = soft_nx | sw;
        if (wr_clr) soft_nx = soft_nx & ~sw;
        soft_nx[0] = 1'b0;
        lmask_nx = lmask_q;
        if (wr_lmset && lbit) lmask_nx = 1'b1;
        if (wr_lmclr && lbit) lmask_nx = 1'b0;
    end

    always_comb begin
        vec = soft_nx | glb_lvl;
        if (tmr && !lmask_nx) vec[TMR_LVL] = 1'b1;
        vec[0] = 1'b0;
    end

    mpil_prio u_prio (
        .vec (vec),
        .lvl (enc_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q  <= '0;
            lmask_q <= 1'b1;
            pil_q   <= 4'd0;
        end else begin
            soft_q  <= soft_nx;
            lmask_q <= lmask_nx;
            pil_q   <= halt ? 4'd0 : enc_lvl;
        end
    end

    // R6
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr) |=> ((soft_q & $past(sw) & 16'hFFFE) == ($past(sw) & 16'hFFFE)));

    // R6
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((soft_q & $past(sw)) == '0));

    // R8
    prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec >> enc_lvl) == ((enc_lvl != 4'd0) ? 16'd1 : 16'd0));

endmodule

// File: rtl/mpil_ctrl.sv
module mpil_ctrl
    import mpil_pkg::*;
#(
    parameter  int NCPU = 2,
    localparam int AW   = $clog2((NCPU + 1) * BLK_WORDS),
    localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDEV-1:0]   dev_irq,
    input  logic [NCPU-1:0]   cpu_tmr,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD-1:0]   bus_wdata,
    output logic [WORD-1:0]   bus_rdata,
    output logic [4*NCPU-1:0] pil
);

    localparam int BW = AW - 3;

    logic [BW-1:0]   blk;
    logic [2:0]      off;
    logic            g_sel;
    logic [WORD-1:0] gmask_q;
    logic [CW-1:0]   tgt_q;
    logic [CW-1:0]   tgt_nx;
    logic            halt_nx;
    logic [LVLS-1:0] lvl_any;
    logic [LVLS-1:0] sw;

    logic [LVLS-1:0] soft_a  [NCPU];
    logic            lmask_a [NCPU];
    logic [3:0]      pil_a   [NCPU];

    assign blk   = bus_addr[AW-1:3];
    assign off   = bus_addr[2:0];
    assign g_sel = (blk == BW'(NCPU));
    assign sw    = {bus_wdata[WORD-1:SOFT_LSB+1], 1'b0};

    mpil_glb #(.CW(CW)) u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mset (bus_we && g_sel && (off == GO_MSET)),
        .wr_mclr (bus_we && g_sel && (off == GO_MCLR)),
        .wr_tgt  (bus_we && g_sel && (off == GO_TGT)),
        .wdata   (bus_wdata),
        .dev_irq (dev_irq),
        .gmask_q (gmask_q),
        .tgt_q   (tgt_q),
        .tgt_nx  (tgt_nx),
        .halt_nx (halt_nx),
        .lvl_any (lvl_any)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic            c_sel;
        logic [LVLS-1:0] routed;

        assign c_sel  = bus_we && (blk == BW'(c));
        assign routed = (tgt_nx == CW'(c)) ? lvl_any : (lvl_any & (16'd1 << ERR_LVL));

        mpil_cpu u_cpu (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_set   (c_sel && (off == CO_SSET)),
            .wr_clr   (c_sel && (off == CO_SCLR)),
            .wr_lmset (c_sel && (off == CO_LMSET)),
            .wr_lmclr (c_sel && (off == CO_LMCLR)),
            .sw       (sw),
            .lbit     (bus_wdata[TMR_BIT]),
            .tmr      (cpu_tmr[c]),
            .glb_lvl  (routed),
            .halt     (halt_nx),
            .soft_q   (soft_a[c]),
            .lmask_q  (lmask_a[c]),
            .pil_q    (pil_a[c])
        );

        assign pil[4*c +: 4] = pil_a[c];

        // R8
        err_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gmask_q[WORD-1] && soft_a[c][ERR_LVL]) |-> (pil_a[c] == 4'd15));

        // R7
        tmr_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!gmask_q[WORD-1] && !lmask_a[c] && $past(cpu_tmr[c])) |-> (pil_a[c] >= 4'd14));
    end

    always_comb begin
        bus_rdata = '0;
        if (g_sel) begin
            case (off)
                GO_PEND: bus_rdata = {1'b0, dev_irq};
                GO_MASK: bus_rdata = gmask_q;
                GO_TGT:  bus_rdata = WORD'(tgt_q);
                default: bus_rdata = '0;
            endcase
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (blk == BW'(c)) begin
                    if (off == CO_PEND)
                        bus_rdata = {soft_a[c][LVLS-1:1], 1'b0, 8'd0, cpu_tmr[c], 7'd0};
                    else if (off == CO_LMASK)
                        bus_rdata = {24'd0, lmask_a[c], 7'd0};
                end
            end
        end
    end

    // R3
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_q[WORD-1] |-> (pil == '0));

endmodule

// File: tb/sim_mpil_ctrl.sv
module sim_mpil_ctrl;

    localparam int NCPU = 2;
    localparam int AW   = 5;

    logic              clk;
    logic              rst_n;
    logic [30:0]       dev_irq;
    logic [NCPU-1:0]   cpu_tmr;
    logic              bus_we;
    logic [AW-1:0]     bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [4*NCPU-1:0] pil;

    int checks = 0;
    int errors = 0;

    mpil_ctrl #(.NCPU(NCPU)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cpu_tmr(cpu_tmr),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pil(pil)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [AW-1:0] ca(input int c, input int o);
        return AW'(c * 8 + o);
    endfunction

    function automatic logic [AW-1:0] ga(input int o);
        return AW'(NCPU * 8 + o);
    endfunction

    function automatic int lvl_of(input int b);
        case (b)
            15: return 15; 16: return 4; 17: return 6; 18: return 8;
            19: return 10; 20: return 13; 21: return 12; 22: return 12;
            23: return 11; 24: return 2; 25: return 3; 26: return 5;
            27: return 7; 28: return 9; 29: return 11; 30: return 13;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lv(input int c, input string req, input int exp);
        chk(req, 32'(pil[4*c +: 4]), 32'(exp));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dev_irq = '0; cpu_tmr = '0;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 pil", 32'(pil), 32'd0);
        rd(ga(1), d); chk("R1 gmask", d, 32'hFFFF_FFFF);
        rd(ca(0, 3), d); chk("R1 lmask0", d, 32'h80);
        rd(ca(1, 0), d); chk("R1 pend1", d, 32'h0);
    endtask

    task automatic t_gmask();
        logic [31:0] d;
        do_reset();
        wr(ga(3), 32'h8008_0000);
        rd(ga(1), d); chk("R2 gmask clr", d, 32'h7FF7_FFFF);
        @(negedge clk); dev_irq[19] = 1'b1;
        @(negedge clk);
        lv(0, "R4 bit19", 10); lv(1, "R5 cpu1 none", 0);
        wr(ga(2), 32'h0008_0000);
        lv(0, "R2 masked", 0);
        rd(ga(1), d); chk("R2 gmask set", d, 32'h7FFF_FFFF);
    endtask

    task automatic t_master_route();
        do_reset();
        wr(ga(3), 32'h8001_0000);
        @(negedge clk); dev_irq[16] = 1'b1;
        @(negedge clk);
        lv(0, "R4 bit16", 4);
        wr(ga(2), 32'h8000_0000);
        chk("R3 master off", 32'(pil), 32'd0);
        wr(ga(3), 32'h8000_0000);
        lv(0, "R3 master on", 4);
        wr(ga(4), 32'd1);
        lv(0, "R5 moved cpu0", 0); lv(1, "R5 moved cpu1", 4);
        wr(ga(3), 32'h0000_8000);
        @(negedge clk); dev_irq[15] = 1'b1;
        @(negedge clk);
        lv(0, "R5 err cpu0", 15); lv(1, "R5 err cpu1", 15);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        do_reset();
        wr(ga(3), 32'h8000_0000);
        wr(ca(1, 1), 32'h0200_0000);
        lv(1, "R6 ipi cpu1", 9); lv(0, "R6 ipi cpu0", 0);
        rd(ca(1, 0), d); chk("R9 pend soft", d, 32'h0200_0000);
        rd(ca(1, 0), d); chk("R9 reread", d, 32'h0200_0000);
        lv(1, "R9 no side effect", 9);
        wr(ca(1, 2), 32'h0200_0000);
        lv(1, "R6 clear", 0);
        wr(ca(0, 1), 32'h0001_FFFF);
        rd(ca(0, 0), d); chk("R6 bit16 ignored", d, 32'h0);
        lv(0, "R6 bit16 pil", 0);
    endtask

    task automatic t_timer_prio();
        logic [31:0] d;
        do_reset();
        wr(ga(3), 32'h8000_0000);
        @(negedge clk); cpu_tmr[0] = 1'b1;
        @(negedge clk);
        lv(0, "R7 masked timer", 0);
        rd(ca(0, 0), d); chk("R9 pend tmr", d, 32'h80);
        wr(ca(0, 5), 32'h80);
        lv(0, "R7 timer", 14); lv(1, "R7 other cpu", 0);
        wr(ca(0, 1), 32'h1000_0000);
        wr(ca(0, 1), 32'h0008_0000);
        lv(0, "R8 timer wins", 14);
        wr(ca(0, 4), 32'h80);
        lv(0, "R8 level 12", 12);
        wr(ca(0, 2), 32'h1000_0000);
        lv(0, "R8 level 3", 3);
        wr(ca(0, 2), 32'h0008_0000);
        lv(0, "R8 none", 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        do_reset();
        wr(ga(3), 32'h8000_0000);
        for (int b = 0; b < 31; b++) begin
            wr(ga(3), 32'd1 << b);
            @(negedge clk); dev_irq = 31'd1 << b;
            @(negedge clk);
            lv(0, $sformatf("R4 map bit %0d", b), lvl_of(b));
            rd(ga(0), d); chk("R9 gpend", d, 32'd1 << b);
            dev_irq = '0;
            wr(ga(2), 32'd1 << b);
        end
    endtask

    task automatic t_same_cycle();
        do_reset();
        wr(ga(3), 32'h8002_0000);
        @(negedge clk);
        dev_irq[17] = 1'b1; bus_we = 1'b1; bus_addr = ga(2); bus_wdata = 32'h0002_0000;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        lv(0, "R10 same cycle a", 0);
        @(negedge clk);
        lv(0, "R10 same cycle b", 0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ga(3); bus_wdata = 32'h0002_0000;
        @(negedge clk);
        bus_we = 1'b0;
        lv(0, "R10 unmask latency", 6);
        @(negedge clk); dev_irq[17] = 1'b0;
        @(negedge clk);
        lv(0, "R10 line drop", 0);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        do_reset();
        wr(ga(4), 32'd1);
        rd(ga(4), d); chk("R11 target rb", d, 32'd1);
        rd(ca(0, 1), d); chk("R11 wo reads 0", d, 32'd0);
        rd(ca(1, 6), d); chk("R11 unused", d, 32'd0);
    endtask

    initial begin
        t_reset();
        t_gmask();
        t_master_route();
        t_soft();
        t_timer_prio();
        t_map();
        t_same_cycle();
        t_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule